// File: doc/BRIEF.md
# Message-Mapped Register File

This block is the general-purpose register file of a small RISC core, doubled to 64 words of 32 bits, in which two register numbers can be turned into windows onto the core's network queues. When the window mapping is on, any instruction that reads register 24 takes the word at the head of the inbound queue and removes it, and any instruction that writes register 25 hands its result to the outbound queue. Ordinary arithmetic instructions can therefore consume and produce network messages with no load or store instructions.

A configuration write sets a two-bit control word. Bit 0 turns the queue windows on, and bit 1 opens the upper 32 registers. With the windows off, registers 24 and 25 are plain storage. When a windowed read finds the inbound queue empty, or a windowed write finds the outbound queue full, the block raises a stall. While the stall is high, the instruction has no effect at all, so the core can replay it unchanged. The queues themselves sit outside the block, which sees them through a head word, an empty flag and a pop strobe on the inbound side, and through a full flag, a push strobe and a data word on the outbound side.

Top module: `msg_regfile`

## Requirements
- R1: Registers 1 to 31 hold 32-bit values. A write presented with `wr_en` lands at the next rising clock edge. Both read ports return the stored word combinationally, in the same cycle the address is presented.
- R2: Register 0 always reads as zero, and writes to it are discarded.
- R3: A rising edge with `cfg_we` high loads `cfg_word` into the control word. Bit 0 of the control word enables the queue windows and bit 1 enables the upper bank. Both bits are cleared by reset.
- R4: While the upper bank is disabled, reads of registers 32 to 63 return zero and writes to them are discarded. Values stored while the bank was enabled survive and are visible again once it is re-enabled.
- R5: With the windows disabled, registers 24 and 25 store and return values like any other register, and `rx_pop` and `tx_push` stay low.
- R6: With the windows enabled, an enabled read port addressing register 24 returns `rx_data`, and `rx_pop` is high in that cycle when `rx_empty` is low.
- R7: When both read ports address register 24 in the same cycle, `rx_pop` is a single strobe and both ports return the same head word.
- R8: With the windows enabled, a write to register 25 drives `tx_push` high with `tx_data` equal to the written value, and the stored register 25 is left unchanged. In this mode, reads of register 25 return zero and writes to register 24 are discarded.
- R9: A windowed read while `rx_empty` is high raises `stall`, keeps `rx_pop` low and returns zero on that port.
- R10: A windowed write while `tx_full` is high raises `stall` and keeps `tx_push` low. The push happens in the first cycle in which `tx_full` is low while the write is still presented.
- R11: While `stall` is high, no queue is popped or pushed and no register is written, even when another part of the same instruction would otherwise have done so.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the control word |
| cfg_word | input | 2 | Control word: bit 1 upper bank, bit 0 queue windows |
| rd_a_en | input | 1 | Read port A is in use |
| rd_a_addr | input | 6 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_en | input | 1 | Read port B is in use |
| rd_b_addr | input | 6 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port strobe |
| wr_addr | input | 6 | Write port register number |
| wr_data | input | 32 | Write port data |
| rx_data | input | 32 | Head word of the inbound queue |
| rx_empty | input | 1 | Inbound queue is empty |
| rx_pop | output | 1 | Remove the inbound head word |
| tx_full | input | 1 | Outbound queue is full |
| tx_push | output | 1 | Append `tx_data` to the outbound queue |
| tx_data | output | 32 | Word for the outbound queue |
| stall | output | 1 | Hold the current instruction |

## Verification
A corrupted control word shows up in the very next cycle. Windowed reads either stop popping or start popping, and upper registers read back zero or stale data. A faulty side-effect gate during a stall does not show up in that cycle. It shows up later: as a missing inbound word on the replayed read, as a doubled outbound push, or as a register that has already been changed when it is read after the stall. The bench therefore reads the affected registers and watches the queue strobes both during the stall and after it ends.

// File: rtl/msg_rf_pkg.sv
package msg_rf_pkg;
  // Control word layout: bit 1 opens the upper bank, bit 0 enables the queue windows
  typedef struct packed {
    logic upper_en;
    logic map_en;
  } rf_cfg_t;

  localparam int CFG_W = 2;
endpackage

// File: rtl/msg_rf_rst_sync.sv
module msg_rf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/msg_rf_cfg.sv
module msg_rf_cfg
  import msg_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_word,
  output rf_cfg_t          cfg_q
);
  rf_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = rf_cfg_t'(cfg_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/msg_rf_store.sv
module msg_rf_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 64,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  input  logic [ADDR_W-1:0] rb,
  output logic [DATA_W-1:0] qa,
  output logic [DATA_W-1:0] qb
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign qa = mem[ra];
  assign qb = mem[rb];
endmodule

// File: rtl/msg_rf_portmap.sv
module msg_rf_portmap
  import msg_rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 64,
  parameter int ADDR_W   = $clog2(NUM_REGS),
  parameter int RX_REG   = 24,
  parameter int TX_REG   = 25
) (
  input  rf_cfg_t           cfg,
  input  logic              rd_a_en,
  input  logic [ADDR_W-1:0] rd_a_addr,
  input  logic [DATA_W-1:0] raw_a,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic              rd_b_en,
  input  logic [ADDR_W-1:0] rd_b_addr,
  input  logic [DATA_W-1:0] raw_b,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              st_we,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_empty,
  output logic              rx_pop,
  input  logic              tx_full,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_data,
  output logic              stall
);
  localparam logic [ADDR_W-1:0] RX_A    = ADDR_W'(RX_REG);
  localparam logic [ADDR_W-1:0] TX_A    = ADDR_W'(TX_REG);
  localparam logic [ADDR_W-1:0] UPPER_A = ADDR_W'(NUM_REGS / 2);

  function automatic logic visible(input logic [ADDR_W-1:0] a, input logic up);
    return (a != '0) && (up || (a < UPPER_A));
  endfunction

  function automatic logic [DATA_W-1:0] plain_read(
    input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] raw, input rf_cfg_t c);
    if (!visible(a, c.upper_en))   return '0;
    if (c.map_en && (a == TX_A))   return '0;
    return raw;
  endfunction

  logic a_rx, b_rx, rx_want, rd_block, w_tx, wr_block, w_alias;

  always_comb begin
    a_rx     = rd_a_en && cfg.map_en && (rd_a_addr == RX_A);
    b_rx     = rd_b_en && cfg.map_en && (rd_b_addr == RX_A);
    rx_want  = a_rx || b_rx;
    rd_block = rx_want && rx_empty;
    w_tx     = wr_en && cfg.map_en && (wr_addr == TX_A);
    wr_block = w_tx && tx_full;
    w_alias  = cfg.map_en && ((wr_addr == RX_A) || (wr_addr == TX_A));
    stall    = rd_block || wr_block;

    rx_pop   = rx_want && !stall;
    tx_push  = w_tx && !stall;
    tx_data  = wr_data;
    st_we    = wr_en && visible(wr_addr, cfg.upper_en) && !w_alias && !stall;

    if (a_rx) rd_a_data = rx_empty ? '0 : rx_data;
    else      rd_a_data = plain_read(rd_a_addr, raw_a, cfg);
    if (b_rx) rd_b_data = rx_empty ? '0 : rx_data;
    else      rd_b_data = plain_read(rd_b_addr, raw_b, cfg);
  end
endmodule

// File: rtl/msg_regfile.sv
module msg_regfile
  import msg_rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 64,
  parameter int ADDR_W   = $clog2(NUM_REGS),
  parameter int RX_REG   = 24,
  parameter int TX_REG   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              rd_a_en,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic              rd_b_en,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_empty,
  output logic              rx_pop,
  input  logic              tx_full,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_data,
  output logic              stall
);
  logic              rst_n_sync;
  rf_cfg_t           cfg_q;
  logic              st_we;
  logic [DATA_W-1:0] raw_a, raw_b;

  msg_rf_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  msg_rf_cfg u_cfg (
    .clk(clk), .rst_n(rst_n_sync), .cfg_we(cfg_we), .cfg_word(cfg_word), .cfg_q(cfg_q)
  );

  msg_rf_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(st_we), .wa(wr_addr), .wd(wr_data),
    .ra(rd_a_addr), .rb(rd_b_addr), .qa(raw_a), .qb(raw_b)
  );

  msg_rf_portmap #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
    .RX_REG(RX_REG), .TX_REG(TX_REG)
  ) u_map (
    .cfg(cfg_q),
    .rd_a_en(rd_a_en), .rd_a_addr(rd_a_addr), .raw_a(raw_a), .rd_a_data(rd_a_data),
    .rd_b_en(rd_b_en), .rd_b_addr(rd_b_addr), .raw_b(raw_b), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .st_we(st_we),
    .rx_data(rx_data), .rx_empty(rx_empty), .rx_pop(rx_pop),
    .tx_full(tx_full), .tx_push(tx_push), .tx_data(tx_data), .stall(stall)
  );
endmodule

// File: rtl/msg_rf_checker.sv
module msg_rf_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int RX_REG = 24,
  parameter int TX_REG = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_a_en,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              rd_b_en,
  input logic [ADDR_W-1:0] rd_b_addr,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_empty,
  input logic              rx_pop,
  input logic              tx_full,
  input logic              tx_push,
  input logic [DATA_W-1:0] tx_data,
  input logic              stall
);
  localparam logic [ADDR_W-1:0] RX_A = ADDR_W'(RX_REG);
  localparam logic [ADDR_W-1:0] TX_A = ADDR_W'(TX_REG);

  assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == '0) |-> (rd_a_data == '0));

  assert_pop_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> ((rd_a_en && rd_a_addr == RX_A) || (rd_b_en && rd_b_addr == RX_A)));

  assert_same_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rd_a_en && rd_b_en && rd_a_addr == RX_A && rd_b_addr == RX_A)
      |-> (rd_a_data == rd_b_data) && (rd_a_data == rx_data));

  assert_push_payload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> (wr_en && wr_addr == TX_A && tx_data == wr_data));

  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> !rx_empty);

  assert_no_push_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> !tx_full);

  assert_quiet_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!rx_pop && !tx_push));
endmodule

bind msg_regfile msg_rf_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RX_REG(RX_REG), .TX_REG(TX_REG)
) i_msg_rf_checker (
  .clk(clk), .rst_n(rst_n),
  .rd_a_en(rd_a_en), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
  .rd_b_en(rd_b_en), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rx_data(rx_data), .rx_empty(rx_empty), .rx_pop(rx_pop),
  .tx_full(tx_full), .tx_push(tx_push), .tx_data(tx_data), .stall(stall)
);

// File: tb/test_msg_regfile.sv
module test_msg_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_word;
  logic        rd_a_en, rd_b_en, wr_en;
  logic [5:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [31:0] rd_a_data, rd_b_data, wr_data, rx_data, tx_data;
  logic        rx_empty, rx_pop, tx_full, tx_push, stall;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  msg_regfile i_msg_regfile (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .rd_a_en(rd_a_en), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_en(rd_b_en), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_data(rx_data), .rx_empty(rx_empty), .rx_pop(rx_pop),
    .tx_full(tx_full), .tx_push(tx_push), .tx_data(tx_data), .stall(stall)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] w);
    cfg_we = 1'b1; cfg_word = w;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic read_a(input logic [5:0] a, input logic [31:0] exp, input string req);
    rd_a_en = 1'b1; rd_a_addr = a;
    #2;
    chk(rd_a_data === exp, req, rd_a_data, exp);
    rd_a_en = 1'b0;
  endtask

  task automatic t_reset();
    rd_a_en = 1'b1; rd_a_addr = 6'd24; rx_empty = 1'b0; rx_data = 32'hDEAD_0001;
    #2;
    chk(rx_pop === 1'b0 && stall === 1'b0, "R3 reset clears window bit", {31'd0, rx_pop}, 32'd0);
    rd_a_en = 1'b0;
    wr(6'd40, 32'h4040_4040);
    read_a(6'd40, 32'd0, "R3 reset clears upper bit");
  endtask

  task automatic t_basic();
    wr(6'd1, 32'h1111_0001);
    wr(6'd31, 32'h3131_3131);
    rd_a_en = 1'b1; rd_a_addr = 6'd1; rd_b_en = 1'b1; rd_b_addr = 6'd31;
    #2;
    chk(rd_a_data === 32'h1111_0001, "R1 port A", rd_a_data, 32'h1111_0001);
    chk(rd_b_data === 32'h3131_3131, "R1 port B", rd_b_data, 32'h3131_3131);
    rd_a_en = 1'b0; rd_b_en = 1'b0;
    wr(6'd0, 32'hFFFF_FFFF);
    read_a(6'd0, 32'd0, "R2 zero register");
  endtask

  task automatic t_upper();
    set_cfg(2'b10);
    wr(6'd40, 32'hAAAA_0040);
    read_a(6'd40, 32'hAAAA_0040, "R4 upper bank open");
    set_cfg(2'b00);
    read_a(6'd40, 32'd0, "R4 upper bank closed reads zero");
    wr(6'd40, 32'hBBBB_0040);
    set_cfg(2'b10);
    read_a(6'd40, 32'hAAAA_0040, "R4 write while closed discarded");
    set_cfg(2'b00);
  endtask

  task automatic t_plain_alias();
    wr_en = 1'b1; wr_addr = 6'd25; wr_data = 32'h2525_2525; tx_full = 1'b0;
    #2;
    chk(tx_push === 1'b0, "R5 no push when windows off", {31'd0, tx_push}, 32'd0);
    step();
    wr_en = 1'b0;
    wr(6'd24, 32'h2424_2424);
    rx_empty = 1'b0;
    rd_a_en = 1'b1; rd_a_addr = 6'd24;
    #2;
    chk(rd_a_data === 32'h2424_2424 && rx_pop === 1'b0, "R5 register 24 plain", rd_a_data, 32'h2424_2424);
    rd_a_en = 1'b0;
    read_a(6'd25, 32'h2525_2525, "R5 register 25 plain");
  endtask

  task automatic t_rx();
    set_cfg(2'b01);
    rx_empty = 1'b0; rx_data = 32'hC0DE_0006;
    rd_a_en = 1'b1; rd_a_addr = 6'd24;
    #2;
    chk(rd_a_data === 32'hC0DE_0006, "R6 head word", rd_a_data, 32'hC0DE_0006);
    chk(rx_pop === 1'b1, "R6 pop strobe", {31'd0, rx_pop}, 32'd1);
    rd_b_en = 1'b1; rd_b_addr = 6'd24; rx_data = 32'hC0DE_0007;
    #2;
    chk(rx_pop === 1'b1 && rd_a_data === rd_b_data && rd_b_data === 32'hC0DE_0007,
        "R7 shared head", rd_b_data, 32'hC0DE_0007);
    rd_a_en = 1'b0; rd_b_en = 1'b0;
    rx_empty = 1'b1; rd_a_en = 1'b1;
    #2;
    chk(stall === 1'b1 && rx_pop === 1'b0, "R9 empty stalls", {30'd0, stall, rx_pop}, 32'd2);
    chk(rd_a_data === 32'd0, "R9 empty data zero", rd_a_data, 32'd0);
    rd_a_en = 1'b0;
  endtask

  task automatic t_tx();
    tx_full = 1'b0;
    wr_en = 1'b1; wr_addr = 6'd25; wr_data = 32'h7E57_0008;
    #2;
    chk(tx_push === 1'b1 && tx_data === 32'h7E57_0008, "R8 push payload", tx_data, 32'h7E57_0008);
    step();
    wr_en = 1'b0;
    read_a(6'd25, 32'd0, "R8 register 25 reads zero");
    wr(6'd24, 32'h9999_9999);
    set_cfg(2'b00);
    read_a(6'd25, 32'h2525_2525, "R8 stored 25 untouched");
    read_a(6'd24, 32'h2424_2424, "R8 write to 24 discarded");
    set_cfg(2'b01);
    tx_full = 1'b1;
    wr_en = 1'b1; wr_addr = 6'd25; wr_data = 32'h7E57_0010;
    #2;
    chk(stall === 1'b1 && tx_push === 1'b0, "R10 full stalls", {30'd0, stall, tx_push}, 32'd2);
    step();
    tx_full = 1'b0;
    #2;
    chk(stall === 1'b0 && tx_push === 1'b1 && tx_data === 32'h7E57_0010,
        "R10 push after space", tx_data, 32'h7E57_0010);
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_stall_quiet();
    wr(6'd5, 32'h0000_0005);
    rx_empty = 1'b1;
    rd_a_en = 1'b1; rd_a_addr = 6'd24;
    wr_en = 1'b1; wr_addr = 6'd5; wr_data = 32'h5555_5555;
    #2;
    chk(stall === 1'b1, "R11 stall raised", {31'd0, stall}, 32'd1);
    step();
    wr_en = 1'b0; rd_a_en = 1'b0;
    read_a(6'd5, 32'h0000_0005, "R11 no register write under stall");
    rx_empty = 1'b0; tx_full = 1'b1;
    rd_a_en = 1'b1; rd_a_addr = 6'd24;
    wr_en = 1'b1; wr_addr = 6'd25; wr_data = 32'h1234_5678;
    #2;
    chk(rx_pop === 1'b0 && stall === 1'b1, "R11 no pop under write stall", {31'd0, rx_pop}, 32'd0);
    step();
    wr_en = 1'b0; rd_a_en = 1'b0; tx_full = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_word = '0;
    rd_a_en = 1'b0; rd_b_en = 1'b0; wr_en = 1'b0;
    rd_a_addr = '0; rd_b_addr = '0; wr_addr = '0; wr_data = '0;
    rx_data = '0; rx_empty = 1'b1; tx_full = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_upper();
    t_plain_alias();
    t_rx();
    t_tx();
    t_stall_quiet();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule